// File: doc/BRIEF.md
# PLL Fault Response Controller

This block owns the control word of a clock synthesizer and turns the health of that synthesizer into system-level actions. It watches a lock-status line from the PLL and a sticky loss-of-clock flag from an external clock monitor. A set of enable bits in the control word decides whether each fault produces a reset request, an interrupt, or neither. A mode input marks the PLL as switched off. While that input is high, every enable is ignored and no request leaves the block.

The control word also holds the modulation rate, modulation depth and reference divider settings that other logic consumes. A master loss-of-clock enable gates the clock-loss reset and interrupt paths. It has no effect on the lock paths, and it drives the enable line of the external monitor and backup-clock logic. A falling edge on the lock input is latched in a sticky flag. That flag stays set until it is cleared through a dedicated clear input.

An enable that is written while its fault is already present acts at once. A reset enable produces a one-cycle reset request. An interrupt enable raises its interrupt line.

Top module: `pll_fault_ctrl`

## Requirements
- R1: After reset the control word reads 0x0003_0000. Every bit is zero except the reference divider field (bits 17:16), which resets to 2'b11.
- R2: The control word layout is: bit 0 clock-loss master enable, bit 1 lock-loss reset enable, bit 2 clock-loss reset enable, bit 3 lock-loss interrupt enable, bit 4 clock-loss interrupt enable, bits 9:8 modulation rate, bits 14:12 modulation depth, bits 17:16 reference divider. A write takes effect at the clock edge that samples the write strobe. All other bits read as zero. Reading has no side effect.
- R3: `clkmon_en` equals the master enable ANDed with not-PLL-off, registered one cycle later.
- R4: While the master enable is 0, the loss-of-clock flag causes neither a reset request nor a clock-loss interrupt.
- R5: The master enable does not gate the lock-loss reset or interrupt paths.
- R6: While `pll_off` is high, `rst_req`, `lol_irq`, `loc_irq` and `clkmon_en` are all low in the following cycle, whatever the enables are.
- R7: Setting the lock-loss reset enable while the lock input is low produces one `rst_req` pulse, one cycle wide. Clearing the enable and setting it again while still unlocked produces a new pulse.
- R8: With the lock-loss reset enable set, a high-to-low transition of the lock input produces a one-cycle `rst_req` pulse in the next cycle.
- R9: A falling edge of the lock input sets a sticky flag. A high `lol_clr` clears it, and a falling edge in the same cycle takes priority over the clear. `lol_irq` is registered from lock-loss interrupt enable AND not-PLL-off AND (sticky flag OR lock low).
- R10: Enabling the clock-loss reset path while the loss-of-clock flag is high produces a one-cycle `rst_req` pulse. Re-enabling it after a clear produces another pulse.
- R11: `loc_irq` is high for as long as the flag, the master enable and the clock-loss interrupt enable all stay set outside PLL-off mode. It falls one cycle after the flag drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_off | input | 1 | PLL switched-off mode indication |
| lock_in | input | 1 | PLL lock status, high when locked |
| loc_flag | input | 1 | Sticky loss-of-clock flag from the external monitor |
| lol_clr | input | 1 | Clears the sticky loss-of-lock flag |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Current control word |
| rst_req | output | 1 | One-cycle system reset request |
| lol_irq | output | 1 | Loss-of-lock interrupt |
| loc_irq | output | 1 | Loss-of-clock interrupt |
| clkmon_en | output | 1 | Enable for the clock monitor and backup-clock logic |

## Verification
The hardest case to reach is a second reset pulse from a fault that never went away. The enable must be cleared and then written again while the lock input stays low or the clock-loss flag stays high. The directed tasks hold the fault input steady across three writes (set, clear, set) and check that a fresh one-cycle pulse follows the last write. The sticky lock flag is another hard case. The bench drops lock, restores it, and then pulses the clear input, so that the flag alone keeps the interrupt high until the clear takes effect.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int REG_W     = 32;
  localparam int RATE_W    = 2;
  localparam int DEPTH_W   = 3;
  localparam int DIV_W     = 2;
  localparam int RATE_LSB  = 8;
  localparam int DEPTH_LSB = 12;
  localparam int DIV_LSB   = 16;
  localparam logic [DIV_W-1:0] DIV_RST = '1;

  localparam int B_LOC_EN     = 0;
  localparam int B_LOL_RST_EN = 1;
  localparam int B_LOC_RST_EN = 2;
  localparam int B_LOL_IRQ_EN = 3;
  localparam int B_LOC_IRQ_EN = 4;

  typedef struct packed {
    logic               loc_en;
    logic               lol_rst_en;
    logic               loc_rst_en;
    logic               lol_irq_en;
    logic               loc_irq_en;
    logic [RATE_W-1:0]  rate;
    logic [DEPTH_W-1:0] depth;
    logic [DIV_W-1:0]   div;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.loc_en     = w[B_LOC_EN];
    c.lol_rst_en = w[B_LOL_RST_EN];
    c.loc_rst_en = w[B_LOC_RST_EN];
    c.lol_irq_en = w[B_LOL_IRQ_EN];
    c.loc_irq_en = w[B_LOC_IRQ_EN];
    c.rate       = w[RATE_LSB  +: RATE_W];
    c.depth      = w[DEPTH_LSB +: DEPTH_W];
    c.div        = w[DIV_LSB   +: DIV_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_W-1:0] w;
    w                         = '0;
    w[B_LOC_EN]               = c.loc_en;
    w[B_LOL_RST_EN]           = c.lol_rst_en;
    w[B_LOC_RST_EN]           = c.loc_rst_en;
    w[B_LOL_IRQ_EN]           = c.lol_irq_en;
    w[B_LOC_IRQ_EN]           = c.loc_irq_en;
    w[RATE_LSB  +: RATE_W]    = c.rate;
    w[DEPTH_LSB +: DEPTH_W]   = c.depth;
    w[DIV_LSB   +: DIV_W]     = c.div;
    return w;
  endfunction

endpackage

// File: rtl/pfc_ctrl_reg.sv
module pfc_ctrl_reg
  import pfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl_q,
  output logic [REG_W-1:0] rd_data
);

  ctrl_t ctrl_d;
  ctrl_t ctrl_rst;

  always_comb begin
    ctrl_rst     = '0;
    ctrl_rst.div = DIV_RST;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_unpack(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= ctrl_rst;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  assign rd_data = ctrl_pack(ctrl_q);

endmodule

// File: rtl/pfc_lock_track.sv
module pfc_lock_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  input  logic lol_clr,
  output logic lol_sticky
);

  logic lock_q;
  logic fall;
  logic sticky_d;

  assign fall = lock_q & ~lock_in;

  always_comb begin
    sticky_d = lol_sticky;
    if (lol_clr) sticky_d = 1'b0;
    if (fall)    sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lol_sticky <= 1'b0;
    end else begin
      lock_q     <= lock_in;
      lol_sticky <= sticky_d;
    end
  end

endmodule

// File: rtl/pfc_fault_req.sv
module pfc_fault_req
  import pfc_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  pll_off,
  input  logic  lock_in,
  input  logic  loc_flag,
  input  logic  lol_sticky,
  output logic  rst_req,
  output logic  lol_irq,
  output logic  loc_irq,
  output logic  clkmon_en
);

  logic            active;
  logic            loc_gate;
  logic [NSRC-1:0] cond;
  logic [NSRC-1:0] cond_q;
  logic [NSRC-1:0] rise;
  logic            rst_d;
  logic            lol_irq_d;
  logic            loc_irq_d;
  logic            clkmon_d;

  assign active   = ~pll_off;
  assign loc_gate = active & ctrl.loc_en;

  always_comb begin
    cond    = '0;
    cond[0] = active & ctrl.lol_rst_en & ~lock_in;
    cond[1] = loc_gate & ctrl.loc_rst_en & loc_flag;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rise[i] = cond[i] & ~cond_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q[i] <= 1'b0;
      else        cond_q[i] <= cond[i];
    end
  end

  always_comb begin
    rst_d     = |rise;
    lol_irq_d = active & ctrl.lol_irq_en & (lol_sticky | ~lock_in);
    loc_irq_d = loc_gate & ctrl.loc_irq_en & loc_flag;
    clkmon_d  = loc_gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req   <= 1'b0;
      lol_irq   <= 1'b0;
      loc_irq   <= 1'b0;
      clkmon_en <= 1'b0;
    end else begin
      rst_req   <= rst_d;
      lol_irq   <= lol_irq_d;
      loc_irq   <= loc_irq_d;
      clkmon_en <= clkmon_d;
    end
  end

endmodule

// File: rtl/pll_fault_ctrl.sv
module pll_fault_ctrl
  import pfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_off,
  input  logic             lock_in,
  input  logic             loc_flag,
  input  logic             lol_clr,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             rst_req,
  output logic             lol_irq,
  output logic             loc_irq,
  output logic             clkmon_en
);

  ctrl_t ctrl_q;
  logic  lol_sticky;

  pfc_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .rd_data (rd_data)
  );

  pfc_lock_track u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_in    (lock_in),
    .lol_clr    (lol_clr),
    .lol_sticky (lol_sticky)
  );

  pfc_fault_req #(.NSRC(2)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl_q),
    .pll_off    (pll_off),
    .lock_in    (lock_in),
    .loc_flag   (loc_flag),
    .lol_sticky (lol_sticky),
    .rst_req    (rst_req),
    .lol_irq    (lol_irq),
    .loc_irq    (loc_irq),
    .clkmon_en  (clkmon_en)
  );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
  import pfc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pll_off,
  input logic             lock_in,
  input logic             loc_flag,
  input logic [REG_W-1:0] rd_data,
  input logic             rst_req,
  input logic             lol_irq,
  input logic             loc_irq,
  input logic             clkmon_en
);

  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pll_off |=> (!rst_req && !lol_irq && !loc_irq && !clkmon_en));

  a_r7_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r4_loc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_LOC_EN] |=> !loc_irq);

  a_r11_loc_level: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_flag && rd_data[B_LOC_EN] && rd_data[B_LOC_IRQ_EN] && !pll_off) |=> loc_irq);

  a_r3_clkmon: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_LOC_EN] && !pll_off) |=> clkmon_en);

  a_r9_unlock_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_in && rd_data[B_LOL_IRQ_EN] && !pll_off) |=> lol_irq);

  a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~32'h0003_731F) == '0);

endmodule

bind pll_fault_ctrl pfc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pll_off   (pll_off),
  .lock_in   (lock_in),
  .loc_flag  (loc_flag),
  .rd_data   (rd_data),
  .rst_req   (rst_req),
  .lol_irq   (lol_irq),
  .loc_irq   (loc_irq),
  .clkmon_en (clkmon_en)
);

// File: tb/tb_pll_fault_ctrl.sv
`timescale 1ns/1ps
module tb_pll_fault_ctrl;

  logic        clk;
  logic        rst_n;
  logic        pll_off;
  logic        lock_in;
  logic        loc_flag;
  logic        lol_clr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rst_req;
  logic        lol_irq;
  logic        loc_irq;
  logic        clkmon_en;

  int n_chk;
  int n_err;

  localparam logic [31:0] RST_VAL = 32'h0003_0000;
  localparam logic [31:0] LOC_EN  = 32'h1;
  localparam logic [31:0] LOLRST  = 32'h2;
  localparam logic [31:0] LOCRST  = 32'h4;
  localparam logic [31:0] LOLIRQ  = 32'h8;
  localparam logic [31:0] LOCIRQ  = 32'h10;

  pll_fault_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_off   (pll_off),
    .lock_in   (lock_in),
    .loc_flag  (loc_flag),
    .lol_clr   (lol_clr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rst_req   (rst_req),
    .lol_irq   (lol_irq),
    .loc_irq   (loc_irq),
    .clkmon_en (clkmon_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Write: strobe is sampled at the next edge; returns at the negedge after it.
  task automatic wr(input logic [31:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    tick();
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic idle_state();
    pll_off  = 1'b0;
    lock_in  = 1'b1;
    loc_flag = 1'b0;
    wr(RST_VAL);
    tick();
    lol_clr = 1'b1;
    tick();
    lol_clr = 1'b0;
    tick();
    tick();
  endtask

  task automatic t_reset();
    chk("R1 reset word", rd_data, RST_VAL);
    chk("R1 reset outputs", {28'd0, rst_req, lol_irq, loc_irq, clkmon_en}, 32'd0);
  endtask

  task automatic t_regs();
    wr(32'hFFFF_FFFF);
    chk("R2 unused bits zero", rd_data, 32'h0003_731F);
    wr(32'h0002_5100);
    chk("R2 field write", rd_data, 32'h0002_5100);
    tick();
    chk("R2 read no side effect", rd_data, 32'h0002_5100);
    wr(RST_VAL);
  endtask

  task automatic t_clkmon();
    idle_state();
    wr(LOC_EN);
    chk("R3 clkmon not yet", {31'd0, clkmon_en}, 32'd0);
    tick();
    chk("R3 clkmon on", {31'd0, clkmon_en}, 32'd1);
    wr(RST_VAL);
    tick();
    chk("R3 clkmon off", {31'd0, clkmon_en}, 32'd0);
  endtask

  task automatic t_loc_gate();
    idle_state();
    loc_flag = 1'b1;
    wr(LOCRST | LOCIRQ);
    tick();
    chk("R4 no reset without master", {31'd0, rst_req}, 32'd0);
    tick();
    chk("R4 no irq without master", {31'd0, loc_irq}, 32'd0);
    chk("R4 no reset later", {31'd0, rst_req}, 32'd0);
    loc_flag = 1'b0;
    wr(RST_VAL);
  endtask

  task automatic t_lol_rst_enable();
    idle_state();
    lock_in = 1'b0;
    tick();
    tick();
    wr(LOLRST);
    tick();
    chk("R7 pulse on enable while unlocked", {31'd0, rst_req}, 32'd1);
    tick();
    chk("R7 pulse one cycle", {31'd0, rst_req}, 32'd0);
    wr(RST_VAL);
    tick();
    wr(LOLRST);
    tick();
    chk("R7 second pulse after rewrite", {31'd0, rst_req}, 32'd1);
    tick();
    chk("R7 second pulse ends", {31'd0, rst_req}, 32'd0);
    wr(RST_VAL);
  endtask

  task automatic t_lol_fall();
    idle_state();
    wr(LOLRST);
    tick();
    chk("R8 no pulse while locked", {31'd0, rst_req}, 32'd0);
    lock_in = 1'b0;
    tick();
    chk("R8 pulse on lock loss", {31'd0, rst_req}, 32'd1);
    tick();
    chk("R8 pulse ends", {31'd0, rst_req}, 32'd0);
    wr(RST_VAL);
  endtask

  task automatic t_lol_irq();
    idle_state();
    wr(LOLIRQ);
    tick();
    chk("R9 irq low while locked", {31'd0, lol_irq}, 32'd0);
    lock_in = 1'b0;
    tick();
    chk("R5 R9 irq on lock loss, master off", {31'd0, lol_irq}, 32'd1);
    lock_in = 1'b1;
    tick();
    tick();
    chk("R9 sticky holds irq", {31'd0, lol_irq}, 32'd1);
    lol_clr = 1'b1;
    tick();
    lol_clr = 1'b0;
    chk("R9 irq one cycle after clear", {31'd0, lol_irq}, 32'd1);
    tick();
    chk("R9 irq cleared", {31'd0, lol_irq}, 32'd0);
    wr(RST_VAL);
  endtask

  task automatic t_loc_rst();
    idle_state();
    loc_flag = 1'b1;
    wr(LOC_EN | LOCRST);
    tick();
    chk("R10 pulse on enable with flag", {31'd0, rst_req}, 32'd1);
    tick();
    chk("R10 pulse ends", {31'd0, rst_req}, 32'd0);
    wr(LOC_EN);
    tick();
    wr(LOC_EN | LOCRST);
    tick();
    chk("R10 second pulse", {31'd0, rst_req}, 32'd1);
    tick();
    chk("R10 second pulse ends", {31'd0, rst_req}, 32'd0);
    loc_flag = 1'b0;
    wr(RST_VAL);
  endtask

  task automatic t_loc_irq();
    idle_state();
    loc_flag = 1'b1;
    wr(LOC_EN | LOCIRQ);
    tick();
    chk("R11 irq on", {31'd0, loc_irq}, 32'd1);
    tick();
    tick();
    chk("R11 irq held", {31'd0, loc_irq}, 32'd1);
    loc_flag = 1'b0;
    tick();
    chk("R11 irq drops with flag", {31'd0, loc_irq}, 32'd0);
    wr(RST_VAL);
  endtask

  task automatic t_off();
    idle_state();
    pll_off  = 1'b1;
    lock_in  = 1'b0;
    loc_flag = 1'b1;
    wr(32'h0000_001F);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R6 quiet in PLL-off", {28'd0, rst_req, lol_irq, loc_irq, clkmon_en}, 32'd0);
    end
    pll_off = 1'b0;
    tick();
    chk("R6 irqs resume after PLL-off", {29'd0, lol_irq, loc_irq, clkmon_en}, 32'd7);
    loc_flag = 1'b0;
    wr(RST_VAL);
  endtask

  initial begin
    n_chk    = 0;
    n_err    = 0;
    rst_n    = 1'b0;
    pll_off  = 1'b0;
    lock_in  = 1'b0;
    loc_flag = 1'b0;
    lol_clr  = 1'b0;
    wr_en    = 1'b0;
    wr_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_clkmon();
    t_loc_gate();
    t_lol_rst_enable();
    t_lol_fall();
    t_lol_irq();
    t_loc_rst();
    t_loc_irq();
    t_off();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule